// File: doc/BRIEF.md
# Per-Core Memory Bandwidth Regulator

This block sits between a group of cores and the shared memory path. It limits how many memory transactions each core may issue in a fixed regulation period. Each core has its own per-period allowance, and the allowances can be weighted differently from core to core. A core that uses up its allowance is held by its stall line. A period counter inside the block ends each period, and at that point every allowance is renewed.

Cores in soft mode give up part of their allowance at the start of each period. The predicted need is the core's own usage in the period just ended, and the unused remainder goes into a shared pool. A soft core that runs dry while it still has traffic draws fixed-size chunks from that pool. When two or more cores want a chunk in the same cycle, a rotating priority picks one. Hard-mode cores neither give nor take. Once every core has run dry and the pool is empty, the block releases all cores into best-effort operation until the period ends.

Top module: `mem_bw_regulator`

## Requirements
- R1: After reset the block is in best-effort state (`best_effort`=1, every `stall` bit 0) until the first period boundary. A boundary falls on every PERIOD-th clock edge after reset is released. Every access issued in best-effort state is accepted.
- R2: An access is accepted when `acc[i]`=1 and `stall[i]`=0. Each accepted access lowers core i's remaining count by one. `stall[i]` is 1 while the remaining count is zero and the block is not in best-effort state. An access raised while stalled is neither accepted nor counted.
- R3: At a boundary, a soft core's remaining count becomes min(allowance, accepted accesses in the ending period). A hard core's remaining count becomes its full allowance.
- R4: At a boundary, the pool is loaded with the sum over soft cores of max(0, allowance − usage in the ending period). Any balance left in the pool from the ending period is discarded.
- R5: A soft core with a zero remaining count, a pending access and a non-empty pool receives min(16, pool) transactions in the cycle it is stalled. It is released in the following cycle.
- R6: When several cores request in the same cycle, exactly one is granted. Priority rotates, starting from the core after the one granted last (core 0 first after reset).
- R7: A core whose `hard` bit is 1 never draws from the pool and is not counted as giving to it.
- R8: When every remaining count is zero and the pool is empty, `best_effort` rises and every `stall` bit drops. This state lasts until the next boundary.
- R9: Allowances are independent per core, packed in `budget` with core i at bits [i*CW +: CW]. Their sum must not exceed the guaranteed per-period capacity GUAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| budget | input | NCORE*CW | Per-core allowance per period, core i at [i*CW +: CW] |
| hard | input | NCORE | 1 = hard reservation for that core |
| acc | input | NCORE | Core issues a memory transaction this cycle |
| stall | output | NCORE | Core must hold its traffic |
| best_effort | output | 1 | All cores released until period end |

## Verification
The hardest situation to reach is a specific mix of pool balance, per-core remaining counts and rotation pointer at a given point in the period. All of that state follows from the usage history of the previous period. The stimulus therefore sets up each period by issuing exact access counts in the period before. It then reads the resulting allowances and pool size at the ports by holding a core's access line high and counting accepted transactions and stall cycles. The pool-discard case is shown by leaving a balance unused at one boundary and checking that the next period's total reclaimable amount equals only the fresh donations.

// File: rtl/mem_bw_regulator.sv
module mem_bw_regulator #(
  parameter int NCORE  = 4,
  parameter int CW     = 10,
  parameter int PERIOD = 200,
  parameter int CHUNK  = 16,
  parameter int GUAR   = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE*CW-1:0]   budget,
  input  logic [NCORE-1:0]      hard,
  input  logic [NCORE-1:0]      acc,
  output logic [NCORE-1:0]      stall,
  output logic                  best_effort
);
  localparam int TW = $clog2(PERIOD);
  localparam int PW = CW + $clog2(NCORE + 1);
  localparam int IW = (NCORE > 1) ? $clog2(NCORE) : 1;

  logic [TW-1:0]              tick;
  logic                       bound;
  logic [NCORE-1:0][CW-1:0]   rem, used, used_nx, don;
  logic [PW-1:0]              pool, don_sum;
  logic [IW-1:0]              last, win;
  logic [NCORE-1:0]           empty, ok, req, gnt;
  logic [CW-1:0]              gamt;

  assign bound       = (tick == TW'(PERIOD - 1));
  assign best_effort = (&empty) && (pool == '0);
  assign gamt        = (pool >= PW'(CHUNK)) ? CW'(CHUNK) : pool[CW-1:0];

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    logic [CW-1:0] bud;
    assign bud        = budget[i*CW +: CW];
    assign empty[i]   = (rem[i] == '0);
    assign stall[i]   = empty[i] && !best_effort;
    assign ok[i]      = acc[i] && !stall[i];
    assign req[i]     = acc[i] && empty[i] && !hard[i] && (pool != '0) && !bound;
    assign used_nx[i] = (ok[i] && used[i] != '1) ? used[i] + 1'b1 : used[i];
    assign don[i]     = (hard[i] || bud <= used_nx[i]) ? '0 : bud - used_nx[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rem[i]  <= '0;
        used[i] <= '0;
      end else if (bound) begin
        rem[i]  <= bud - don[i];
        used[i] <= '0;
      end else begin
        used[i] <= used_nx[i];
        if (gnt[i])               rem[i] <= gamt;
        else if (ok[i] && !empty[i]) rem[i] <= rem[i] - 1'b1;
      end
    end
  end

  always_comb begin
    don_sum = '0;
    for (int i = 0; i < NCORE; i++) don_sum = don_sum + PW'(don[i]);
  end

  always_comb begin
    logic found;
    gnt   = '0;
    win   = last;
    found = 1'b0;
    for (int off = 1; off <= NCORE; off++) begin
      int k;
      k = (int'(last) + off) % NCORE;
      if (!found && req[k]) begin
        gnt[k] = 1'b1;
        win    = IW'(k);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      pool <= '0;
      last <= IW'(NCORE - 1);
    end else begin
      tick <= bound ? '0 : tick + 1'b1;
      if (bound)     pool <= don_sum;
      else if (|gnt) pool <= pool - PW'(gamt);
      if (|gnt) last <= win;
    end
  end
endmodule

// File: rtl/mem_bw_regulator_chk.sv
module mem_bw_regulator_chk #(
  parameter int NCORE = 4,
  parameter int CW    = 10,
  parameter int PW    = 13,
  parameter int GUAR  = 128
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCORE*CW-1:0]       budget,
  input logic [NCORE-1:0]          hard,
  input logic [NCORE-1:0]          stall,
  input logic                      best_effort,
  input logic [NCORE-1:0][CW-1:0]  rem,
  input logic [PW-1:0]             pool,
  input logic [NCORE-1:0]          gnt,
  input logic                      bound
);
  int bsum;
  always_comb begin
    bsum = 0;
    for (int i = 0; i < NCORE; i++) bsum = bsum + int'(budget[i*CW +: CW]);
  end

  a_r9_budget_sum: assert property (@(posedge clk) disable iff (!rst_n)
    bound |-> bsum <= GUAR);

  a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r4_pool_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (pool > $past(pool)) |-> $past(bound));

  a_r8_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (best_effort && !bound) |=> best_effort);

  for (genvar i = 0; i < NCORE; i++) begin : g_chk
    a_r5_grant_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> stall[i]);

    a_r7_hard_no_draw: assert property (@(posedge clk) disable iff (!rst_n)
      hard[i] |-> !gnt[i]);

    a_r2_rem_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (rem[i] > $past(rem[i])) |-> ($past(bound) || $past(gnt[i])));
  end
endmodule

bind mem_bw_regulator mem_bw_regulator_chk #(
  .NCORE(NCORE), .CW(CW), .PW(CW + $clog2(NCORE + 1)), .GUAR(GUAR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .budget(budget), .hard(hard), .stall(stall),
  .best_effort(best_effort), .rem(rem), .pool(pool), .gnt(gnt), .bound(bound)
);

// File: tb/sim_mem_bw_regulator.sv
`timescale 1ns/1ps
module sim_mem_bw_regulator;
  localparam int N = 4, CW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N*CW-1:0] budget;
  logic [N-1:0] hard = '0, acc = '0, stall;
  logic best_effort;
  int nchk = 0, nfail = 0, cyc = 0;
  int got [N];

  always #2 clk = ~clk;

  mem_bw_regulator #(.NCORE(N), .CW(CW), .PERIOD(200), .CHUNK(16), .GUAR(128)) u0 (
    .clk(clk), .rst_n(rst_n), .budget(budget), .hard(hard), .acc(acc),
    .stall(stall), .best_effort(best_effort));

  task automatic check(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic run(logic [N-1:0] m, int n);
    for (int c = 0; c < N; c++) got[c] = 0;
    acc = m;
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < N; c++) if (m[c] && !stall[c]) got[c]++;
      step();
    end
    acc = '0;
  endtask

  task automatic idle_until(int t);
    while (cyc < t) step();
  endtask

  task automatic t_reset_period0();
    check("R1 reset best_effort", int'(best_effort), 1);
    check("R1 reset stall", int'(stall), 0);
    run(4'b0001, 3);  check("R1 core0 accepted", got[0], 3);
    run(4'b0010, 20); check("R1 core1 accepted", got[1], 20);
    run(4'b1000, 64); check("R1 core3 accepted", got[3], 64);
    idle_until(199);
    check("R1 still released before boundary", int'(best_effort), 1);
  endtask

  task automatic t_reload_and_reclaim();
    idle_until(200);
    check("R3 stall after reload", int'(stall), 4'b0100);
    check("R4 pool non-empty, not released", int'(best_effort), 0);
    run(4'b0010, 90);
    check("R5 core1 own 16 plus pool 37", got[1], 53);
    run(4'b0001, 10);
    check("R3 core0 min(budget,usage)", got[0], 3);
    idle_until(300);
    run(4'b1000, 64);
    check("R3 core3 full budget", got[3], 64);
    check("R8 release when all dry", int'(best_effort), 1);
    check("R8 no stall when released", int'(stall), 0);
    idle_until(398);
    hard = 4'b0001;
    check("R8 release lasts to boundary", int'(best_effort), 1);
  endtask

  task automatic t_hard_and_rotation();
    idle_until(400);
    check("R8 release ends at boundary", int'(best_effort), 0);
    run(4'b0001, 12);
    check("R7 hard core gets only its budget", got[0], 8);
    run(4'b0010, 16);
    check("R2 core1 decrements to stall", got[1], 16);
    acc = 4'b0110;
    check("R6 both requesters stalled", int'(stall[2:1]), 2'b11);
    step();
    check("R6 rotation grants core2 first", int'(stall[2:1]), 2'b01);
    run(4'b0110, 39);
    check("R6 core2 chunk", got[2], 16);
    check("R6 core1 chunk after", got[1], 16);
    idle_until(500);
    hard = '0;
  endtask

  task automatic t_discard();
    idle_until(600);
    run(4'b1000, 20);
    check("R5 chunks of 16 with one-cycle stall", got[3], 18);
    idle_until(800);
    run(4'b0010, 130);
    check("R4 leftover pool discarded", got[1], 102);
  endtask

  initial begin
    budget = {10'd64, 10'd32, 10'd16, 10'd8};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    t_reset_period0();
    t_reload_and_reclaim();
    t_hard_and_rotation();
    t_discard();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(4 * 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule